// File: doc/BRIEF.md
# 4x4 Unsigned Wallace Multiplier with Skip-Carry Final Adder

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product in the same cycle. It has no registers. All sixteen partial-product bits come from AND gates. Two carry-save levels of full and half adders compress them. A 4-bit adder then produces the top five product bits. This adder ripples carries inside each 2-bit group and uses a multiplexer to pass a group's carry-in straight through when every bit of the group propagates.

The low product bits come straight from points inside the tree. Bit 0 is the weight-0 partial product. Bit 1 is the first-level sum in column 1. Bit 2 is the second-level sum in column 2. The sum and carry vectors of both compression levels are driven onto debug ports, so a netlist can be checked level by level.

Top module: `wallace_mul4`

## Requirements
- R1: For every pair of operands, prod_o equals a_i times b_i as an unsigned 8-bit value.
- R2: prod_o[0] equals a_i[0] AND b_i[0].
- R3: lvl1_sum_o (bit k at weight 2^(k+1)) plus lvl1_cry_o (bit k at weight 2^(k+2)) equals a_i times b_i[2:0], minus the weight-0 bit a_i[0]&b_i[0], minus the weight-32 bit a_i[3]&b_i[2].
- R4: lvl2_sum_o (bit k at weight 2^(k+2)) plus lvl2_cry_o (bit k at weight 2^(k+3)) equals a_i times b_i, minus a_i[0]&b_i[0], minus 2 times (a_i[1]&b_i[0] XOR a_i[0]&b_i[1]), minus 64 times a_i[3]&b_i[3].
- R5: prod_o[1] equals lvl1_sum_o[0] and prod_o[2] equals lvl2_sum_o[0].
- R6: prod_o[7:3] equals the 5-bit sum of {a_i[3]&b_i[3], lvl2_sum_o[3:1]} and lvl2_cry_o. This holds in particular when one 2-bit group of those operands propagates on every bit and its carry-in has to be skipped across.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Multiplicand, unsigned |
| b_i | input | 4 | Multiplier, unsigned |
| prod_o | output | 8 | Product a_i*b_i |
| lvl1_sum_o | output | 4 | First compression level sums, columns 1..4 |
| lvl1_cry_o | output | 4 | First compression level carries, weights 2..5 |
| lvl2_sum_o | output | 4 | Second compression level sums, columns 2..5 |
| lvl2_cry_o | output | 4 | Second compression level carries, weights 3..6 |

## Verification
The block holds no state, so a wrong gate or a misrouted carry shows up at the ports as soon as the operands settle. Such a fault changes the product only for the operand pairs that excite it. A fault inside the compression tree also breaks the weighted-sum identity of the debug vectors for the level where it sits, which tells you which level is at fault even when the product happens to come out right. A broken skip multiplexer only shows when a group propagates fully and its carry-in is 1. Checking all 256 operand pairs reaches that case.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned SKIP_G = 2;
  typedef logic [OP_W-1:0]   op_t;
  typedef logic [PROD_W-1:0] prod_t;
endpackage

// File: rtl/wmul_ha.sv
module wmul_ha (
  input  logic x_i,
  input  logic y_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = x_i ^ y_i;
  assign cry_o = x_i & y_i;
endmodule

// File: rtl/wmul_fa.sv
module wmul_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic sum_o,
  output logic cry_o
);
  logic xy;
  assign xy    = x_i ^ y_i;
  assign sum_o = xy ^ z_i;
  assign cry_o = (x_i & y_i) | (xy & z_i);
endmodule

// File: rtl/wmul_skip_add.sv
module wmul_skip_add #(
  parameter int unsigned W   = 4,
  parameter int unsigned GRP = 2
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NGRP = W / GRP;

  logic [NGRP:0] grp_c;
  assign grp_c[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP:0]   rc;
    logic [GRP-1:0] prop;
    assign rc[0] = grp_c[g];
    for (genvar k = 0; k < GRP; k++) begin : g_bit
      assign prop[k] = x_i[g*GRP+k] ^ y_i[g*GRP+k];
      wmul_fa u_fa (
        .x_i  (x_i[g*GRP+k]),
        .y_i  (y_i[g*GRP+k]),
        .z_i  (rc[k]),
        .sum_o(sum_o[g*GRP+k]),
        .cry_o(rc[k+1])
      );
    end
    // full propagate: skip the ripple path
    assign grp_c[g+1] = (&prop) ? grp_c[g] : rc[GRP];
  end

  assign cout_o = grp_c[NGRP];
endmodule

// File: rtl/wallace_mul4.sv
module wallace_mul4
  import wmul_pkg::*;
(
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [OP_W-1:0]   lvl1_sum_o,
  output logic [OP_W-1:0]   lvl1_cry_o,
  output logic [OP_W-1:0]   lvl2_sum_o,
  output logic [OP_W-1:0]   lvl2_cry_o
);
  // pp[j][i] = a[i] & b[j], weight i+j
  logic [OP_W-1:0][OP_W-1:0] pp;
  for (genvar j = 0; j < OP_W; j++) begin : g_row
    for (genvar i = 0; i < OP_W; i++) begin : g_col
      assign pp[j][i] = a_i[i] & b_i[j];
    end
  end

  logic [OP_W-1:0] s1, c1, s2, c2, s3;
  logic            cout;

  // level 1: rows 0..2, columns 1..4
  wmul_ha u_l1_c1 (.x_i(pp[0][1]), .y_i(pp[1][0]), .sum_o(s1[0]), .cry_o(c1[0]));
  wmul_fa u_l1_c2 (.x_i(pp[0][2]), .y_i(pp[1][1]), .z_i(pp[2][0]), .sum_o(s1[1]), .cry_o(c1[1]));
  wmul_fa u_l1_c3 (.x_i(pp[0][3]), .y_i(pp[1][2]), .z_i(pp[2][1]), .sum_o(s1[2]), .cry_o(c1[2]));
  wmul_ha u_l1_c4 (.x_i(pp[1][3]), .y_i(pp[2][2]), .sum_o(s1[3]), .cry_o(c1[3]));

  // level 2: carries shifted one column left, row 3 merged, columns 2..5
  wmul_ha u_l2_c2 (.x_i(s1[1]), .y_i(c1[0]), .sum_o(s2[0]), .cry_o(c2[0]));
  wmul_fa u_l2_c3 (.x_i(s1[2]), .y_i(c1[1]), .z_i(pp[3][0]), .sum_o(s2[1]), .cry_o(c2[1]));
  wmul_fa u_l2_c4 (.x_i(s1[3]), .y_i(c1[2]), .z_i(pp[3][1]), .sum_o(s2[2]), .cry_o(c2[2]));
  wmul_fa u_l2_c5 (.x_i(pp[2][3]), .y_i(c1[3]), .z_i(pp[3][2]), .sum_o(s2[3]), .cry_o(c2[3]));

  // final: columns 3..6
  wmul_skip_add #(.W(OP_W), .GRP(SKIP_G)) u_fin (
    .x_i   ({pp[3][3], s2[3:1]}),
    .y_i   (c2),
    .cin_i (1'b0),
    .sum_o (s3),
    .cout_o(cout)
  );

  assign prod_o     = {cout, s3, s2[0], s1[0], pp[0][0]};
  assign lvl1_sum_o = s1;
  assign lvl1_cry_o = c1;
  assign lvl2_sum_o = s2;
  assign lvl2_cry_o = c2;
endmodule

// File: rtl/wallace_mul4_chk.sv
module wallace_mul4_chk
  import wmul_pkg::*;
(
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic [PROD_W-1:0] prod_o,
  input logic [OP_W-1:0]   lvl1_sum_o,
  input logic [OP_W-1:0]   lvl1_cry_o,
  input logic [OP_W-1:0]   lvl2_sum_o,
  input logic [OP_W-1:0]   lvl2_cry_o
);
  logic [PROD_W-1:0] ref_p;
  logic [PROD_W-1:0] l1_v, l1_ref, l2_v, l2_ref;
  logic [4:0]        top_ref;

  always_comb begin
    ref_p   = PROD_W'(a_i) * PROD_W'(b_i);
    l1_v    = (PROD_W'(lvl1_sum_o) << 1) + (PROD_W'(lvl1_cry_o) << 2);
    l1_ref  = PROD_W'(a_i) * PROD_W'(b_i[2:0]) - PROD_W'(a_i[0] & b_i[0])
            - (PROD_W'(a_i[3] & b_i[2]) << 5);
    l2_v    = (PROD_W'(lvl2_sum_o) << 2) + (PROD_W'(lvl2_cry_o) << 3);
    l2_ref  = ref_p - PROD_W'(a_i[0] & b_i[0])
            - (PROD_W'((a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1])) << 1)
            - (PROD_W'(a_i[3] & b_i[3]) << 6);
    top_ref = 5'({a_i[3] & b_i[3], lvl2_sum_o[3:1]}) + 5'(lvl2_cry_o);
  end

  always_comb begin
    // R1
    prod_exact_chk: assert (prod_o == ref_p);
    // R2
    lsb_direct_chk: assert (prod_o[0] == (a_i[0] & b_i[0]));
    // R3
    lvl1_weight_chk: assert (l1_v == l1_ref);
    // R4
    lvl2_weight_chk: assert (l2_v == l2_ref);
    // R5
    low_tap_chk: assert (prod_o[1] == lvl1_sum_o[0] && prod_o[2] == lvl2_sum_o[0]);
    // R6
    final_add_chk: assert (prod_o[7:3] == top_ref);
  end
endmodule

bind wallace_mul4 wallace_mul4_chk i_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .prod_o    (prod_o),
  .lvl1_sum_o(lvl1_sum_o),
  .lvl1_cry_o(lvl1_cry_o),
  .lvl2_sum_o(lvl2_sum_o),
  .lvl2_cry_o(lvl2_cry_o)
);

// File: tb/test_wallace_mul4.sv
module test_wallace_mul4;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a, b;
  logic [7:0] prod;
  logic [3:0] s1, c1, s2, c2;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wallace_mul4 i_wallace_mul4 (
    .a_i(a), .b_i(b), .prod_o(prod),
    .lvl1_sum_o(s1), .lvl1_cry_o(c1), .lvl2_sum_o(s2), .lvl2_cry_o(c2)
  );

  function automatic int exp_prod(int x, int y);
    return x * y;
  endfunction

  function automatic int exp_l1(int x, int y);
    return x * (y & 7) - ((x & y) & 1) - (((x >> 3) & (y >> 2) & 1) << 5);
  endfunction

  function automatic int exp_l2(int x, int y);
    int s11;
    s11 = ((x >> 1) & y & 1) ^ (x & (y >> 1) & 1);
    return x * y - ((x & y) & 1) - 2 * s11 - (((x >> 3) & (y >> 3) & 1) << 6);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(int x, int y);
    @(posedge clk);
    a = 4'(x);
    b = 4'(y);
    @(negedge clk);
    check("R1", int'(prod), exp_prod(x, y));
    check("R2", int'(prod[0]), (x & y) & 1);
    check("R3", (int'(s1) << 1) + (int'(c1) << 2), exp_l1(x, y));
    check("R4", (int'(s2) << 2) + (int'(c2) << 3), exp_l2(x, y));
    check("R5", {30'd0, prod[2:1]}, {30'd0, s2[0], s1[0]});
    check("R6", int'(prod[7:3]),
          int'({((x >> 3) & (y >> 3) & 1) != 0, s2[3:1]}) + int'(c2));
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    a = '0;
    b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset/idle state, R1 with zero operands
    @(negedge clk);
    check("R1", int'(prod), 0);
    // directed corners: extremes, single bits, skip-path patterns (R6)
    apply(15, 15);
    apply(15, 1);
    apply(1, 15);
    apply(8, 8);
    apply(0, 15);
    apply(5, 10);
    apply(10, 5);
    apply(7, 9);
    apply(11, 13);
    // random mix
    for (int n = 0; n < 100; n++) apply(int'($urandom_range(15)), int'($urandom_range(15)));
    // exhaustive, R1..R6
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) apply(x, y);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule